// File: doc/BRIEF.md
# Vertical-Blank Interrupt Unit

This unit sits between a video timing generator and a system interrupt controller. It watches the raw vertical-blank level and keeps a pending status bit that tracks that level. It drives a single interrupt line. Software reaches it through two word-wide registers: an enable word and a status word.

The raw blank level passes through a synchroniser first. Only its edges change the status bit. A status change reaches the interrupt line only while the enable bit is set. Software dismisses a pending interrupt with a handshake on a clear bit held in the enable word. It first writes that bit as 1, then writes it as 0, and the falling write drops the pending condition. The status word cannot be written.

All pins are plain control and status signals. There is no streaming interface and no back-pressure. A register write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_sel`.

Top module: `vbl_irq_unit`

## Requirements
- R1: After reset, the status bit, every stored enable bit and `irq` are all 0.
- R2: A rising edge of `vbl_raw` sets status bit 0, and a falling edge clears it. The new value is visible three clock edges after the input changes: two synchroniser stages, then the edge register.
- R3: A status change drives `irq` to the new status value only if enable bit 0, as stored before that edge, is 1. Otherwise `irq` holds its value, including when enable bit 0 is set later.
- R4: A write to the enable register (`wr_sel`=0) with `wr_data[1]`=0, while stored enable bit 1 is 1, clears the status on that edge. `irq` also drops if enable bit 0 is 1. Writing bit 1 as 0 when it is already 0, or writing it as 1, does not clear the status.
- R5: The enable register stores only `wr_data[3:0]`. Bit 0 is the interrupt enable, bit 1 is the clear bit, and bits 2 and 3 are stored with no other effect. Higher written bits are discarded and read back as 0.
- R6: `rd_data` shows the enable register zero-extended when `rd_sel`=0. When `rd_sel`=1 it shows the status word, which carries the status in bit 0 and zeros above it.
- R7: When a clear write and a synchronised rising blank edge fall on the same edge, the rising edge wins and the status stays set.
- R8: Writes to the status register (`wr_sel`=1) have no effect on the status or on `irq`.
- R9: A blank level that stays high does not set the status again after a clear. Only a new rising edge sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbl_raw | input | 1 | Raw vertical-blank level from the timing generator, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 enable, 1 status |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 enable, 1 status |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt line toward the interrupt controller |

## Verification
The blank input is toggled both with the enable bit set and with it cleared. This shows whether status changes are gated on their way to `irq`, as opposed to being copied straight to the line or refreshed when the enable bit is written. Clear writes are tried three ways: a true 1-to-0 transition, a 0-to-0 rewrite, and a 1-to-1 rewrite. These separate a transition-sensitive clear from one that merely looks at the level. A clear write is lined up on the exact edge where a synchronised rising edge lands, to check which of the two wins. A clear made while the blank is still held high shows that the status follows edges rather than the level.

// File: rtl/vbl_irq_pkg.sv
package vbl_irq_pkg;
  localparam int REG_W  = 32;
  localparam int EN_W   = 4;
  localparam int EN_IE  = 0;
  localparam int EN_CLR = 1;
  localparam int ST_VBL = 0;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_STATUS = 1'b1
  } vbl_sel_e;
endpackage

// File: rtl/vbl_sync_edge.sv
module vbl_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~last_q;
  assign fall  = ~level & last_q;
endmodule

// File: rtl/vbl_status_core.sv
module vbl_status_core (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic drop_evt,
  input  logic clr_evt,
  input  logic irq_en,
  output logic stat_q,
  output logic irq_q
);
  logic stat_n;

  always_comb begin
    if (set_evt)                  stat_n = 1'b1;
    else if (drop_evt || clr_evt) stat_n = 1'b0;
    else                          stat_n = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      if ((stat_n != stat_q) && irq_en) irq_q <= stat_n;
    end
  end
endmodule

// File: rtl/vbl_irq_unit.sv
module vbl_irq_unit
  import vbl_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vbl_raw,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic            vbl_lvl, vbl_rise, vbl_fall;
  logic [EN_W-1:0] en_q;
  logic            en_wr, clr_evt, stat_q;
  logic            unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:EN_W] ^ vbl_lvl;

  vbl_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (vbl_raw),
    .level    (vbl_lvl),
    .rise     (vbl_rise),
    .fall     (vbl_fall)
  );

  assign en_wr   = wr_en && (vbl_sel_e'(wr_sel) == SEL_ENABLE);
  assign clr_evt = en_wr && en_q[EN_CLR] && !wr_data[EN_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wr_data[EN_W-1:0];
  end

  vbl_status_core core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (vbl_rise),
    .drop_evt (vbl_fall),
    .clr_evt  (clr_evt),
    .irq_en   (en_q[EN_IE]),
    .stat_q   (stat_q),
    .irq_q    (irq)
  );

  always_comb begin
    rd_data = '0;
    if (vbl_sel_e'(rd_sel) == SEL_ENABLE) rd_data[EN_W-1:0] = en_q;
    else                                  rd_data[ST_VBL]   = stat_q;
  end
endmodule

// File: rtl/vbl_irq_unit_chk.sv
module vbl_irq_unit_chk
  import vbl_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             rd_sel,
  input logic [REG_W-1:0] rd_data,
  input logic             irq,
  input logic [EN_W-1:0]  en_q,
  input logic             stat_q,
  input logic             vbl_rise,
  input logic             vbl_fall,
  input logic             clr_evt
);
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_rise |=> stat_q); // R2

  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_fall && !vbl_rise) |=> !stat_q); // R2

  AST_IRQ_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[EN_IE] |=> $stable(irq)); // R3

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq) |-> (irq == stat_q)); // R3

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !vbl_rise) |=> !stat_q); // R4

  AST_EN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 1'b0) |-> (rd_data[REG_W-1:EN_W] == '0)); // R5

  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 1'b1) |-> (rd_data[REG_W-1:1] == '0)); // R6

  AST_RISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && vbl_rise) |=> stat_q); // R7

  AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !vbl_rise && !vbl_fall) |=> $stable(stat_q)); // R8
endmodule

bind vbl_irq_unit vbl_irq_unit_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .rd_sel   (rd_sel),
  .rd_data  (rd_data),
  .irq      (irq),
  .en_q     (en_q),
  .stat_q   (stat_q),
  .vbl_rise (vbl_rise),
  .vbl_fall (vbl_fall),
  .clr_evt  (clr_evt)
);

// File: tb/vbl_irq_unit_tb_top.sv
module vbl_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vbl_raw = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vbl_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .vbl_raw(vbl_raw),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel;
    #0.5;
    v = rd_data;
  endtask

  task automatic blank(input logic v);
    @(negedge clk);
    vbl_raw = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(1'b0, v); check("R1 enable", v, 32'h0);
    rd(1'b1, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    wr(1'b0, 32'h1);
    @(negedge clk); vbl_raw = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(1'b1, v); check("R2 not yet after two edges", v, 32'h0);
    @(negedge clk);
    rd(1'b1, v); check("R2 set after three edges", v, 32'h1);
    check("R3 irq follows when enabled", {31'b0, irq}, 32'h1);
    blank(1'b0);
    rd(1'b1, v); check("R2 falling edge clears", v, 32'h0);
    check("R3 irq drops when enabled", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_gated;
    logic [31:0] v;
    wr(1'b0, 32'h0);
    blank(1'b1);
    rd(1'b1, v); check("R2 status set while disabled", v, 32'h1);
    check("R3 irq held while disabled", {31'b0, irq}, 32'h0);
    wr(1'b0, 32'h1);
    check("R3 enabling does not refresh irq", {31'b0, irq}, 32'h0);
    blank(1'b0);
    check("R3 irq unchanged on 1->0 status", {31'b0, irq}, 32'h0);
    blank(1'b1);
    check("R3 irq rises on next change", {31'b0, irq}, 32'h1);
    blank(1'b0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(1'b0, 32'h3);
    blank(1'b1);
    wr(1'b0, 32'h3);
    rd(1'b1, v); check("R4 1->1 clear write keeps status", v, 32'h1);
    wr(1'b0, 32'h1);
    rd(1'b1, v); check("R4 1->0 clear write drops status", v, 32'h0);
    check("R4 irq dropped by clear", {31'b0, irq}, 32'h0);
    repeat (5) @(negedge clk);
    rd(1'b1, v); check("R9 held level does not reassert", v, 32'h0);
    blank(1'b0);
    blank(1'b1);
    wr(1'b0, 32'h1);
    rd(1'b1, v); check("R4 0->0 clear write keeps status", v, 32'h1);
    blank(1'b0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(1'b0, 32'h3);
    @(negedge clk); vbl_raw = 1'b1;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    rd(1'b1, v); check("R7 rising edge beats clear", v, 32'h1);
    check("R7 irq set", {31'b0, irq}, 32'h1);
    blank(1'b0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(1'b0, 32'hFFFF_FFF5);
    rd(1'b0, v); check("R5 upper bits discarded", v, 32'h5);
    rd(1'b0, v); check("R6 enable readback", v, 32'h5);
    wr(1'b0, 32'h1);
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, v); check("R8 status write ignored (set)", v, 32'h0);
    check("R8 irq unaffected", {31'b0, irq}, 32'h0);
    blank(1'b1);
    wr(1'b1, 32'h0);
    rd(1'b1, v); check("R8 status write ignored (clear)", v, 32'h1);
    rd(1'b1, v); check("R6 status readback", v, 32'h1);
    check("R8 irq kept", {31'b0, irq}, 32'h1);
    blank(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_gated();
    t_clear();
    t_collide();
    t_regs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule